// File: doc/BRIEF.md
# Unaligned Left/Right Access Merge Unit

This block performs the byte merging behind partial-word "left" and "right" accesses of a 64-bit load/store pipeline. Each access works on one aligned word (4 bytes) or one aligned doubleword (8 bytes). The low address bits give a byte offset, and that offset decides which bytes come from memory and which come from the register. A load combines the aligned memory data with the old value of the destination register and returns the result for write-back. A store reads the aligned location, merges the register bytes into it, and writes the whole location back.

The unit accepts one operation at a time on a one-cycle `start` strobe. It latches the opcode, the address, the register value and a flag that marks the destination as the hard-wired zero register. It then runs a short sequence against a simple memory port. The port has a one-cycle request and a read response that may come any number of cycles later. Stores add a write request after the response. A one-cycle `done` pulse ends every operation. Byte order is little-endian. None of these forms raises an alignment fault.

Top module: `uam_unit`

## Requirements
- R1: The memory address is the effective address with its low 2 bits cleared for word forms (op[1]=0) or its low 3 bits cleared for doubleword forms (op[1]=1). A word store drives strobe 0x0F, with its data in bits 31:0 and bits 63:32 at zero. A doubleword store drives strobe 0xFF.
- R2: Word left load, offset k (0..3): the low 32 bits are (mem[31:0] << 8*(3-k)) OR (reg[31:0] AND (0xFFFFFFFF >> 8*(k+1))). The result is sign-extended from bit 31 to 64 bits.
- R3: Word right load, offset k (0..3): the low 32 bits are (mem[31:0] >> 8*k) OR (reg[31:0] AND NOT(0xFFFFFFFF >> 8*k)). At k=0 the result is sign-extended to 64 bits. At k=1..3 bits 63:32 equal the old register bits 63:32.
- R4: Doubleword left load, offset k (0..7): (mem << 8*(7-k)) OR (reg AND (all-ones >> 8*(k+1))). Doubleword right load: (mem >> 8*k) OR (reg AND NOT(all-ones >> 8*k)).
- R5: Word left store writes (reg >> 8*(3-k)) OR (mem AND NOT(0xFFFFFFFF >> 8*(3-k))). Word right store writes (reg << 8*k) OR (mem AND NOT(0xFFFFFFFF << 8*k)). Both work on 32 bits.
- R6: Doubleword left store writes (reg >> 8*(7-k)) OR (mem AND NOT(all-ones >> 8*(7-k))). Doubleword right store writes (reg << 8*k) OR (mem AND NOT(all-ones << 8*k)).
- R7: The opcode uses op[2]=1 for store, op[1]=1 for doubleword and op[0]=1 for the right form. A `start` seen while idle gives a one-cycle read request (mem_req=1, mem_we=0) in the next cycle. The unit then waits for `mem_rvalid`. For a load, `done` and `rf_we` are high for one cycle right after the response cycle, and `busy` is high from the request cycle through the `done` cycle.
- R8: For a store, a one-cycle write request (mem_req=1, mem_we=1) follows the response cycle. `done` follows one cycle after it, and `rf_we` stays low.
- R9: A load whose zero-destination flag is set still issues its read and still pulses `done`, but `rf_we` stays low.
- R10: A `start` seen while busy is ignored. It leaves the running operation's opcode, address, register and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | {store, doubleword, right} |
| eff_addr | input | ADDR_W | Unaligned effective address |
| reg_old | input | 64 | Register value (load target or store source) |
| dest_zero | input | 1 | Destination is the zero register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Aligned memory address |
| mem_wdata | output | 64 | Merged store data |
| mem_wstrb | output | 8 | Byte strobes for writes |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Aligned read data |
| rf_we | output | 1 | Register write enable |
| rf_wdata | output | 64 | Merged load result |

## Verification
The case hardest to reach from the ports is a fresh `start` that arrives while an operation is still in flight, together with changed opcode, address, register and flag inputs. Only a unit that re-latches its inputs, or that leaves its own state too early, shows a wrong merge or a misplaced request in that case. The stimulus holds a competing `start` with inverted operands through every busy cycle of selected operations, and varies the read latency so that each state is held over several cycles. The sign-extension edges are covered by sweeping every offset of every form with two data patterns whose merged top byte has the sign bit set in one pattern and clear in the other.

// File: rtl/uam_pkg.sv
package uam_pkg;
   // opcode bit positions
   localparam int OP_RIGHT_BIT = 0;
   localparam int OP_DWORD_BIT = 1;
   localparam int OP_STORE_BIT = 2;

   localparam int REG_W = 64;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_WAIT  = 3'd2,
      ST_WRITE = 3'd3,
      ST_DONE  = 3'd4
   } uam_state_e;
endpackage

// File: rtl/uam_lane.sv
module uam_lane #(
   parameter int NB = 4
) (
   input  logic [$clog2(NB)-1:0] ofs,
   input  logic [8*NB-1:0]       reg_v,
   input  logic [8*NB-1:0]       mem_v,
   output logic [8*NB-1:0]       ld_left,
   output logic [8*NB-1:0]       ld_right,
   output logic [8*NB-1:0]       st_left,
   output logic [8*NB-1:0]       st_right
);
   localparam int W  = 8 * NB;
   localparam int OW = $clog2(NB);
   localparam logic [W-1:0]  ONES = '1;
   localparam logic [OW-1:0] TOP  = OW'(NB - 1);

   if (NB < 2 || (1 << OW) != NB) begin : g_bad_nb
      $error("uam_lane: NB must be a power of two, at least 2");
   end

   logic [OW+2:0] sh_lo;
   logic [OW+2:0] sh_hi;

   assign sh_lo = {ofs, 3'b000};
   assign sh_hi = {TOP - ofs, 3'b000};

   // loads: memory bytes slide toward the offset, register fills the rest
   assign ld_left  = (reg_v & ((ONES >> sh_lo) >> 8)) | (mem_v << sh_hi);
   assign ld_right = (reg_v & ~(ONES >> sh_lo))       | (mem_v >> sh_lo);
   // stores: register bytes slide into the aligned location, memory fills the rest
   assign st_left  = (reg_v >> sh_hi) | (mem_v & ~(ONES >> sh_hi));
   assign st_right = (reg_v << sh_lo) | (mem_v & ~(ONES << sh_lo));
endmodule

// File: rtl/uam_seq.sv
module uam_seq
   import uam_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       is_store,
   input  logic       rvalid,
   output uam_state_e state,
   output logic       accept,
   output logic       capture
);
   uam_state_e nxt;

   assign accept  = (state == ST_IDLE) && start;
   assign capture = (state == ST_WAIT) && rvalid;

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:  if (start) nxt = ST_READ;
         ST_READ:  nxt = ST_WAIT;
         ST_WAIT:  if (rvalid) nxt = is_store ? ST_WRITE : ST_DONE;
         ST_WRITE: nxt = ST_DONE;
         ST_DONE:  nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   // R7: no response means the wait state holds
   assert_hold_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !rvalid) |=> (state == ST_WAIT));

   // R8: a write phase only follows a captured response
   assert_write_after_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WRITE) |-> $past(capture));
endmodule

// File: rtl/uam_unit.sv
module uam_unit
   import uam_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op,
   input  logic [ADDR_W-1:0] eff_addr,
   input  logic [63:0]       reg_old,
   input  logic              dest_zero,
   output logic              busy,
   output logic              done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [63:0]       mem_wdata,
   output logic [7:0]        mem_wstrb,
   input  logic              mem_rvalid,
   input  logic [63:0]       mem_rdata,
   output logic              rf_we,
   output logic [63:0]       rf_wdata
);
   localparam int WORD_B  = 4;
   localparam int DWORD_B = 8;
   localparam int WORD_W  = 8 * WORD_B;
   localparam int WOFS_W  = $clog2(WORD_B);
   localparam int DOFS_W  = $clog2(DWORD_B);
   localparam logic [7:0] STRB_WORD  = 8'((1 << WORD_B) - 1);
   localparam logic [7:0] STRB_DWORD = 8'((1 << DWORD_B) - 1);

   if (ADDR_W < DOFS_W + 1) begin : g_bad_addr
      $error("uam_unit: ADDR_W too small for doubleword alignment");
   end

   uam_state_e        state;
   logic              accept;
   logic              capture;
   logic [2:0]        op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [REG_W-1:0]  reg_q;
   logic              dz_q;
   logic [REG_W-1:0]  res_q;
   logic [REG_W-1:0]  merged;

   logic [WORD_W-1:0] w_ll, w_lr, w_sl, w_sr;
   logic [REG_W-1:0]  d_ll, d_lr, d_sl, d_sr;

   wire is_store = op_q[OP_STORE_BIT];
   wire is_dword = op_q[OP_DWORD_BIT];
   wire is_right = op_q[OP_RIGHT_BIT];

   uam_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .is_store (is_store),
      .rvalid   (mem_rvalid),
      .state    (state),
      .accept   (accept),
      .capture  (capture)
   );

   uam_lane #(.NB(WORD_B)) u_word (
      .ofs      (addr_q[WOFS_W-1:0]),
      .reg_v    (reg_q[WORD_W-1:0]),
      .mem_v    (mem_rdata[WORD_W-1:0]),
      .ld_left  (w_ll),
      .ld_right (w_lr),
      .st_left  (w_sl),
      .st_right (w_sr)
   );

   uam_lane #(.NB(DWORD_B)) u_dword (
      .ofs      (addr_q[DOFS_W-1:0]),
      .reg_v    (reg_q),
      .mem_v    (mem_rdata),
      .ld_left  (d_ll),
      .ld_right (d_lr),
      .st_left  (d_sl),
      .st_right (d_sr)
   );

   // pick the merged value and its upper-half treatment
   always_comb begin
      case ({is_store, is_dword, is_right})
         3'b000: merged = {{(REG_W-WORD_W){w_ll[WORD_W-1]}}, w_ll};
         3'b001: merged = (addr_q[WOFS_W-1:0] == '0)
                          ? {{(REG_W-WORD_W){w_lr[WORD_W-1]}}, w_lr}
                          : {reg_q[REG_W-1:WORD_W], w_lr};
         3'b010: merged = d_ll;
         3'b011: merged = d_lr;
         3'b100: merged = {{(REG_W-WORD_W){1'b0}}, w_sl};
         3'b101: merged = {{(REG_W-WORD_W){1'b0}}, w_sr};
         3'b110: merged = d_sl;
         default: merged = d_sr;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= '0;
         addr_q <= '0;
         reg_q  <= '0;
         dz_q   <= 1'b0;
         res_q  <= '0;
      end else begin
         if (accept) begin
            op_q   <= op;
            addr_q <= eff_addr;
            reg_q  <= reg_old;
            dz_q   <= dest_zero;
         end
         if (capture) res_q <= merged;
      end
   end

   assign busy     = (state != ST_IDLE);
   assign done     = (state == ST_DONE);
   assign mem_req  = (state == ST_READ) || (state == ST_WRITE);
   assign mem_we   = (state == ST_WRITE);
   assign mem_addr = is_dword ? {addr_q[ADDR_W-1:DOFS_W], {DOFS_W{1'b0}}}
                              : {addr_q[ADDR_W-1:WOFS_W], {WOFS_W{1'b0}}};
   assign mem_wdata = res_q;
   assign mem_wstrb = mem_we ? (is_dword ? STRB_DWORD : STRB_WORD) : 8'h00;
   assign rf_we     = done && !is_store && !dz_q;
   assign rf_wdata  = res_q;

   // R1: requests never carry offset bits
   assert_req_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[WOFS_W-1:0] == '0) && (!is_dword || mem_addr[DOFS_W-1:0] == '0));

   // R2: left word load result is sign-extended
   assert_left_word_signext_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && !is_dword && !is_right) |-> (rf_wdata[REG_W-1:WORD_W] == {(REG_W-WORD_W){rf_wdata[WORD_W-1]}}));

   // R3: right word load at a nonzero offset keeps the old upper half
   assert_right_word_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && !is_dword && is_right && addr_q[WOFS_W-1:0] != '0)
         |-> (rf_wdata[REG_W-1:WORD_W] == reg_q[REG_W-1:WORD_W]));

   // R7: every request lasts exactly one cycle
   assert_single_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R8: a write request follows a read response
   assert_write_after_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> $past(mem_rvalid));

   // R9: zero destination never writes the register file
   assert_zero_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && dz_q) |-> !rf_we);

   // R10: operands stay put while busy
   assert_busy_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(op_q) && $stable(addr_q) && $stable(reg_q) && $stable(dz_q)));
endmodule

// File: tb/sim_uam_unit.sv
module sim_uam_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk;
   logic        rst_n;
   logic        start_i;
   logic [2:0]  op_i;
   logic [31:0] addr_i;
   logic [63:0] reg_i;
   logic        dz_i;
   logic        rvalid_i;
   logic [63:0] rdata_i;
   logic        busy, done, mem_req, mem_we, rf_we;
   logic [31:0] mem_addr;
   logic [63:0] mem_wdata, rf_wdata;
   logic [7:0]  mem_wstrb;

   int vectors = 0;
   int fails   = 0;
   bit finished = 0;

   // reference model state
   int          ms = 0;   // 0 idle, 1 read, 2 wait, 3 write, 4 done
   logic [2:0]  m_op;
   logic [31:0] m_addr;
   logic [63:0] m_reg;
   logic [63:0] m_res;
   logic        m_dz;
   string       ctl_tag = "R7";

   uam_unit #(.ADDR_W(32)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start_i), .op(op_i), .eff_addr(addr_i),
      .reg_old(reg_i), .dest_zero(dz_i), .busy(busy), .done(done),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_rvalid(rvalid_i),
      .mem_rdata(rdata_i), .rf_we(rf_we), .rf_wdata(rf_wdata)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // byte-wise reference for every form
   function automatic logic [63:0] ref_result(input logic [2:0] op, input logic [31:0] a,
                                              input logic [63:0] r, input logic [63:0] m);
      int n = op[1] ? 8 : 4;
      int k = op[1] ? int'(a[2:0]) : int'(a[1:0]);
      logic [63:0] o = '0;
      for (int i = 0; i < n; i++) begin
         int j;
         case ({op[2], op[0]})
            2'b00: begin j = i - (n - 1 - k); if (j >= 0) o[8*i +: 8] = m[8*j +: 8]; else o[8*i +: 8] = r[8*i +: 8]; end
            2'b01: begin j = i + k;           if (j < n)  o[8*i +: 8] = m[8*j +: 8]; else o[8*i +: 8] = r[8*i +: 8]; end
            2'b10: begin j = i + (n - 1 - k); if (j < n)  o[8*i +: 8] = r[8*j +: 8]; else o[8*i +: 8] = m[8*i +: 8]; end
            default: begin j = i - k;         if (j >= 0) o[8*i +: 8] = r[8*j +: 8]; else o[8*i +: 8] = m[8*i +: 8]; end
         endcase
      end
      if (!op[1] && !op[2]) begin
         if (!op[0] || k == 0) o[63:32] = {32{o[31]}};
         else                  o[63:32] = r[63:32];
      end
      return o;
   endfunction

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      bit exp_req = (ms == 1) || (ms == 3);
      bit exp_rfwe = (ms == 4) && !m_op[2] && !m_dz;
      string dtag = m_op[1] ? (m_op[2] ? "R6" : "R4") : (m_op[2] ? "R5" : (m_op[0] ? "R3" : "R2"));
      chk(ctl_tag, "busy", 64'(busy), 64'(ms != 0));
      chk(ctl_tag, "done", 64'(done), 64'(ms == 4));
      chk(ctl_tag, "mem_req", 64'(mem_req), 64'(exp_req));
      chk(ctl_tag, "rf_we", 64'(rf_we), 64'(exp_rfwe));
      if (exp_req) begin
         chk(ctl_tag, "mem_we", 64'(mem_we), 64'(ms == 3));
         chk("R1", "mem_addr", 64'(mem_addr),
             m_op[1] ? 64'({m_addr[31:3], 3'b000}) : 64'({m_addr[31:2], 2'b00}));
      end
      if (ms == 3) begin
         chk("R1", "mem_wstrb", 64'(mem_wstrb), m_op[1] ? 64'hFF : 64'h0F);
         chk(dtag, "mem_wdata", mem_wdata, m_res);
      end
      if (exp_rfwe) chk(dtag, "rf_wdata", rf_wdata, m_res);
   endtask

   task automatic model_step();
      case (ms)
         0: if (start_i) begin m_op = op_i; m_addr = addr_i; m_reg = reg_i; m_dz = dz_i; ms = 1; end
         1: ms = 2;
         2: if (rvalid_i) begin m_res = ref_result(m_op, m_addr, m_reg, rdata_i); ms = m_op[2] ? 3 : 4; end
         3: ms = 4;
         default: ms = 0;
      endcase
   endtask

   task automatic txn(input logic [2:0] op, input logic [31:0] a, input logic [63:0] r,
                      input logic [63:0] m, input logic dz, input int lat, input bit stray);
      bit seen = 0;
      int wcnt = 0;
      op_i = op; addr_i = a; reg_i = r; rdata_i = m; dz_i = dz;
      start_i = 1'b1; rvalid_i = 1'b0;
      ctl_tag = dz ? "R9" : (stray ? "R10" : (op[2] ? "R8" : "R7"));
      while (1) begin
         @(posedge clk);
         model_step();
         @(negedge clk);
         compare();
         if (ms != 0) seen = 1;
         start_i = 1'b0; rvalid_i = 1'b0;
         if (seen && ms == 0) break;
         if (stray) begin
            // competing start with inverted operands, must be ignored (R10)
            start_i = 1'b1; op_i = ~op; addr_i = ~a; reg_i = ~r; dz_i = ~dz;
         end
         if (ms == 2) begin
            if (wcnt >= lat) rvalid_i = 1'b1;
            wcnt++;
         end
      end
   endtask

   initial begin
      rst_n = 1'b0; start_i = 1'b0; op_i = '0; addr_i = '0; reg_i = '0;
      dz_i = 1'b0; rvalid_i = 1'b0; rdata_i = '0;
      m_op = '0; m_addr = '0; m_reg = '0; m_res = '0; m_dz = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      ctl_tag = "R7";
      compare();   // reset state: idle, no request, no write
      rst_n = 1'b1;
      @(negedge clk);
      compare();

      // every form, every offset, two data patterns
      for (int op = 0; op < 8; op++) begin
         int nofs = op[1] ? 8 : 4;
         for (int k = 0; k < nofs; k++) begin
            for (int pat = 0; pat < 2; pat++) begin
               logic [31:0] a = 32'h1000_0040 + 32'(pat * 4) + 32'(k) + 32'(op * 32'h100);
               logic [63:0] r = pat ? 64'hFEDC_BA98_7654_3210 : 64'h0123_4567_89AB_CDEF;
               logic [63:0] m = pat ? 64'h1122_3344_5566_7708 : 64'hF0E1_D2C3_B4A5_9687;
               txn(3'(op), a, r, m, 1'b0, (k + pat) % 3, (k == 1 && pat == 1));
            end
         end
      end

      // zero destination on each load form (R9)
      for (int op = 0; op < 4; op++) begin
         txn(3'(op), 32'h2000_0003 + 32'(op), 64'h5A5A_5A5A_A5A5_A5A5, 64'h8899_AABB_CCDD_EEFF, 1'b1, 1, 1'b0);
      end

      // long response latency with a competing start on stores (R8, R10)
      txn(3'b110, 32'h3000_0005, 64'hCAFE_F00D_1234_5678, 64'h0BAD_BEEF_0BAD_BEEF, 1'b0, 6, 1'b1);
      txn(3'b101, 32'h3000_0002, 64'hDEAD_0000_8765_4321, 64'h7777_7777_7777_7777, 1'b0, 4, 1'b1);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog R7: got hung run expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule